// File: doc/BRIEF.md
# Reference-Edge Injection Sequencer

This block controls a recirculating ring oscillator that is re-aligned to a clean reference clock once every N output cycles. The bit clock, the reference clock and the divider's end-of-count pulse are all sampled on one fast oversampling clock. When the divider reports its final cycle, the sequencer waits for the next bit-clock falling edge and then raises a select window. While this window is open, the oscillator is held and its input multiplexer passes the reference edge. The window closes only when the reference clock and the bit clock are both high. A window that opens ahead of the reference edge therefore always gets a minimum width, and oscillation restarts in phase with the reference.

Inside the window, a phase compare drives two correction strobes. The lag strobe is high while the reference is high and the bit clock is still low. The lead strobe is high for the opposite case. Each strobe's width, counted in oversampling cycles, is reported when the window closes. A monitor counts window cycles that pass without a reference rising edge. Each programmable timeout it flags a missing reference edge, and after a programmable run of consecutive misses it asks for a loop reset. A lock flag follows a run of windows whose lag and lead counts are nearly equal.

Top module: `edge_inject_seq`

## Requirements
- R1: `selOut` goes high on the clock edge after a sample in which the bit clock fell (bit clock 1 in the previous sample, 0 now), provided an end-of-count pulse has been seen since the last window opened, or is present in that same sample.
- R2: An open window closes on the edge after the first sample with both clocks high. Until then it stays open, including while the reference is high and the bit clock is still low.
- R3: `upOut` is high on the edge after each in-window sample with the reference high and the bit clock low. `dnOut` is high on the edge after each in-window sample with the bit clock high and the reference low. The two are never high together, and neither is high outside a window.
- R4: At window close, `upWidth` and `dnWidth` report that window's lag and lead sample counts, saturating at the counter maximum, together with a one-cycle `widthValid` pulse.
- R5: `missOut` pulses for one cycle each time `missTimeout` consecutive window samples have passed with no reference rising edge (reference 0 in the previous sample, 1 now). The miss count is floor(S / missTimeout), where S is the number of window samples taken before the reference rises.
- R6: `resetReqOut` pulses together with the miss that brings the consecutive-miss run to `missLimit`, and the run then restarts from zero. A reference rising edge inside a window also clears the run.
- R7: `lockedOut` rises at the close of the `lockNeed`-th consecutive window whose lag and lead counts differ by at most one. A window that fails this test, or any miss, clears the flag and the run.
- R8: While reset is asserted, and right after it is released, all outputs are low and the widths are zero.
- R9: A bit-clock falling edge with no pending end-of-count pulse does not open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Sampled bit clock |
| rclkIn | input | 1 | Sampled reference clock |
| lastIn | input | 1 | Divider end-of-count pulse |
| missTimeout | input | TMO_W | Window samples allowed before a miss (at least 1) |
| missLimit | input | MISS_W | Consecutive misses that trigger a reset request |
| lockNeed | input | LOCK_W | Good windows in a row needed for lock |
| selOut | output | 1 | Multiplexer select window |
| upOut | output | 1 | Lag correction strobe |
| dnOut | output | 1 | Lead correction strobe |
| upWidth | output | CNT_W | Lag count of the last closed window |
| dnWidth | output | CNT_W | Lead count of the last closed window |
| widthValid | output | 1 | One-cycle pulse when widths update |
| lockedOut | output | 1 | Lock flag |
| missOut | output | 1 | Missing reference edge pulse |
| resetReqOut | output | 1 | Loop reset request pulse |

## Verification
The assertions assume that the end-of-count pulse arrives while the bit clock is high and outside any window. They also assume that the reference clock is low when a window opens, so that its rising edge can be seen inside the window. The stimulus builds every bit-clock period as two high samples followed by two low samples, puts the end-of-count pulse on the first high sample of the Nth period, and keeps the reference low until the window is open. Inside the window it raises the reference and the bit clock with a random offset and order, and sometimes holds both low for a chosen number of samples to provoke misses at and around the timeout boundary.

// File: rtl/injseq_pkg.sv
package injseq_pkg;

  typedef struct packed {
    logic inWin;
    logic opening;
    logic closing;
    logic refRise;
    logic miss;
    logic lagSmp;
    logic leadSmp;
  } win_strobe_t;

endpackage

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import injseq_pkg::*;
#(
  parameter int TMO_W  = 12,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              rclkIn,
  input  logic              lastIn,
  input  logic [TMO_W-1:0]  missTimeout,
  input  logic [MISS_W-1:0] missLimit,
  output logic              selOut,
  output logic              missOut,
  output logic              resetReqOut,
  output win_strobe_t       stb
);

  logic              bPrev, rPrev, armed, sel, refSeen;
  logic [TMO_W-1:0]  tmr;
  logic [MISS_W-1:0] missRun, missRunNext;
  logic              missQ, rrqQ;
  logic              bFall, refRise, openNow, closeNow, tmoHit, runHit;

  always_comb begin
    bFall       = bPrev & ~bclkIn;
    refRise     = ~rPrev & rclkIn;
    openNow     = ~sel & (armed | lastIn) & bFall;
    closeNow    = sel & rclkIn & bclkIn;
    tmoHit      = sel & ~refSeen & ~refRise & ~closeNow &
                  (tmr == missTimeout - TMO_W'(1));
    missRunNext = missRun + MISS_W'(1);
    runHit      = tmoHit & (missRunNext >= missLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev   <= 1'b0;
      rPrev   <= 1'b0;
      armed   <= 1'b0;
      sel     <= 1'b0;
      refSeen <= 1'b0;
      tmr     <= '0;
      missRun <= '0;
      missQ   <= 1'b0;
      rrqQ    <= 1'b0;
    end else begin
      bPrev <= bclkIn;
      rPrev <= rclkIn;
      missQ <= tmoHit;
      rrqQ  <= runHit;
      if (openNow) begin
        sel     <= 1'b1;
        armed   <= 1'b0;
        refSeen <= 1'b0;
        tmr     <= '0;
      end else begin
        if (lastIn) armed <= 1'b1;
        if (closeNow) sel <= 1'b0;
        if (sel) begin
          if (refRise) refSeen <= 1'b1;
          if (tmoHit) tmr <= '0;
          else if (!refSeen) tmr <= tmr + TMO_W'(1);
        end
      end
      if (sel && refRise) missRun <= '0;
      else if (runHit)    missRun <= '0;
      else if (tmoHit)    missRun <= missRunNext;
    end
  end

  assign selOut      = sel;
  assign missOut     = missQ;
  assign resetReqOut = rrqQ;

  always_comb begin
    stb.inWin   = sel;
    stb.opening = openNow;
    stb.closing = closeNow;
    stb.refRise = refRise;
    stb.miss    = tmoHit;
    stb.lagSmp  = sel & rclkIn & ~bclkIn;
    stb.leadSmp = sel & bclkIn & ~rclkIn;
  end

endmodule

// File: rtl/inj_phase_dp.sv
module inj_phase_dp
  import injseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  win_strobe_t       stb,
  input  logic [LOCK_W-1:0] lockNeed,
  output logic              upOut,
  output logic              dnOut,
  output logic [CNT_W-1:0]  upWidth,
  output logic [CNT_W-1:0]  dnWidth,
  output logic              widthValid,
  output logic              lockedOut
);

  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [LOCK_W-1:0] LOCK_MAX = '1;

  logic [1:0] smp;
  logic       upQ, dnQ, validQ, lockedQ;
  logic [LOCK_W-1:0] lockRun, runInc;
  logic [CNT_W-1:0]  lagAcc, leadAcc;
  logic              goodWin;

  assign smp = {stb.leadSmp, stb.lagSmp};

  for (genvar g = 0; g < 2; g++) begin : gDir
    logic [CNT_W-1:0] acc, wid;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc <= '0;
        wid <= '0;
      end else begin
        if (stb.closing) wid <= acc;
        if (stb.closing || stb.opening) acc <= '0;
        else if (smp[g] && acc != CNT_MAX) acc <= acc + CNT_W'(1);
      end
    end
  end

  assign lagAcc  = gDir[0].acc;
  assign leadAcc = gDir[1].acc;

  always_comb begin
    if (lagAcc >= leadAcc) goodWin = (lagAcc - leadAcc) <= CNT_W'(1);
    else                   goodWin = (leadAcc - lagAcc) <= CNT_W'(1);
    runInc = (lockRun == LOCK_MAX) ? lockRun : lockRun + LOCK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      validQ  <= 1'b0;
      lockRun <= '0;
      lockedQ <= 1'b0;
    end else begin
      upQ    <= stb.lagSmp;
      dnQ    <= stb.leadSmp;
      validQ <= stb.closing;
      if (stb.miss) begin
        lockRun <= '0;
        lockedQ <= 1'b0;
      end else if (stb.closing) begin
        if (goodWin) begin
          lockRun <= runInc;
          lockedQ <= (runInc >= lockNeed);
        end else begin
          lockRun <= '0;
          lockedQ <= 1'b0;
        end
      end
    end
  end

  assign upOut      = upQ;
  assign dnOut      = dnQ;
  assign upWidth    = gDir[0].wid;
  assign dnWidth    = gDir[1].wid;
  assign widthValid = validQ;
  assign lockedOut  = lockedQ;

endmodule

// File: rtl/edge_inject_seq.sv
module edge_inject_seq
  import injseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 12,
  parameter int MISS_W = 4,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bclkIn,
  input  logic              rclkIn,
  input  logic              lastIn,
  input  logic [TMO_W-1:0]  missTimeout,
  input  logic [MISS_W-1:0] missLimit,
  input  logic [LOCK_W-1:0] lockNeed,
  output logic              selOut,
  output logic              upOut,
  output logic              dnOut,
  output logic [CNT_W-1:0]  upWidth,
  output logic [CNT_W-1:0]  dnWidth,
  output logic              widthValid,
  output logic              lockedOut,
  output logic              missOut,
  output logic              resetReqOut
);

  win_strobe_t stb;

  inj_ctrl #(.TMO_W(TMO_W), .MISS_W(MISS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .rclkIn(rclkIn), .lastIn(lastIn),
    .missTimeout(missTimeout), .missLimit(missLimit),
    .selOut(selOut), .missOut(missOut), .resetReqOut(resetReqOut), .stb(stb)
  );

  inj_phase_dp #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lockNeed(lockNeed),
    .upOut(upOut), .dnOut(dnOut), .upWidth(upWidth), .dnWidth(dnWidth),
    .widthValid(widthValid), .lockedOut(lockedOut)
  );

endmodule

// File: rtl/edge_inject_seq_chk.sv
module edge_inject_seq_chk (
  input logic clk,
  input logic rstN,
  input logic bclkIn,
  input logic rclkIn,
  input logic selOut,
  input logic upOut,
  input logic dnOut,
  input logic widthValid,
  input logic missOut,
  input logic resetReqOut
);

  a_r1_open_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selOut) |-> ($past(bclkIn, 2) && !$past(bclkIn)));

  a_r2_close_on_both_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selOut) |-> ($past(rclkIn) && $past(bclkIn)));

  a_r3_strobes_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (upOut || dnOut) |-> $past(selOut));

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(upOut && dnOut));

  a_r4_valid_on_close: assert property (@(posedge clk) disable iff (!rstN)
    widthValid |-> $fell(selOut));

  a_r5_miss_in_window: assert property (@(posedge clk) disable iff (!rstN)
    missOut |-> $past(selOut));

  a_r6_reset_with_miss: assert property (@(posedge clk) disable iff (!rstN)
    resetReqOut |-> missOut);

endmodule

bind edge_inject_seq edge_inject_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .rclkIn(rclkIn), .selOut(selOut),
  .upOut(upOut), .dnOut(dnOut), .widthValid(widthValid), .missOut(missOut),
  .resetReqOut(resetReqOut)
);

// File: tb/edge_inject_seq_tb.sv
`timescale 1ns/1ps
module edge_inject_seq_tb;

  localparam int TMO = 20;
  localparam int LIM = 3;
  localparam int LCK = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b0, rclkIn = 1'b0, lastIn = 1'b0;
  logic selOut, upOut, dnOut, widthValid, lockedOut, missOut, resetReqOut;
  logic [7:0] upWidth, dnWidth;

  int total = 0, bad = 0, cyc = 0;
  int upSeen, dnSeen, missSeen, rrqSeen, validSeen, gotUp, gotDn;
  int modelRun = 0;

  always #2.5 clk = ~clk;

  edge_inject_seq u_dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .rclkIn(rclkIn), .lastIn(lastIn),
    .missTimeout(12'(TMO)), .missLimit(4'(LIM)), .lockNeed(4'(LCK)),
    .selOut(selOut), .upOut(upOut), .dnOut(dnOut), .upWidth(upWidth),
    .dnWidth(dnWidth), .widthValid(widthValid), .lockedOut(lockedOut),
    .missOut(missOut), .resetReqOut(resetReqOut)
  );

  always @(negedge clk) begin
    if (upOut) upSeen++;
    if (dnOut) dnSeen++;
    if (missOut) missSeen++;
    if (resetReqOut) rrqSeen++;
    if (widthValid) begin
      validSeen++;
      gotUp = int'(upWidth);
      gotDn = int'(dnWidth);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit b, input bit r, input bit l);
    @(negedge clk);
    #1;
    bclkIn = b; rclkIn = r; lastIn = l;
  endtask

  function automatic int expMisses(input int selSamples);
    return selSamples / TMO;
  endfunction

  // n periods, reference/bit-clock offset d, leadRef: reference rises first,
  // hold: window samples with both clocks low before the pattern
  task automatic window(input int n, input int d, input bit leadRef, input int hold);
    int m, expRrq, run;
    bit good;
    upSeen = 0; dnSeen = 0; missSeen = 0; rrqSeen = 0; validSeen = 0;
    gotUp = -1; gotDn = -1;
    for (int p = 0; p < n; p++) begin
      if (p == 1) chk(selOut == 1'b0, "R9 fall without end-of-count", int'(selOut), 0);
      tick(1, 0, p == n - 1);
      tick(1, 0, 0);
      tick(0, 0, 0);
      tick(0, 0, 0);
    end
    chk(selOut == 1'b1, "R1 window opens after fall", int'(selOut), 1);
    for (int h = 0; h < hold; h++) tick(0, 0, 0);
    for (int k = 0; k < d; k++) tick(leadRef ? 1'b0 : 1'b1, leadRef, 0);
    if (d >= 2) chk(selOut == 1'b1, "R2 stays open before both high", int'(selOut), 1);
    tick(1, 1, 0);
    tick(1, 1, 0);
    tick(0, 0, 0);
    tick(0, 0, 0);
    tick(0, 0, 0);
    chk(selOut == 1'b0, "R2 closed after both high", int'(selOut), 0);
    // expectations
    m = expMisses(1 + hold + (leadRef ? 0 : d));
    expRrq = 0; run = 0;
    for (int i = 0; i < m; i++) begin
      run++;
      if (run >= LIM) begin expRrq++; run = 0; end
    end
    chk(missSeen == m, "R5 miss count", missSeen, m);
    chk(rrqSeen == expRrq, "R6 reset requests", rrqSeen, expRrq);
    chk(upSeen == (leadRef ? d : 0), "R3 lag strobe cycles", upSeen, leadRef ? d : 0);
    chk(dnSeen == (leadRef ? 0 : d), "R3 lead strobe cycles", dnSeen, leadRef ? 0 : d);
    chk(validSeen == 1, "R4 one valid pulse", validSeen, 1);
    chk(gotUp == (leadRef ? d : 0), "R4 lag width", gotUp, leadRef ? d : 0);
    chk(gotDn == (leadRef ? 0 : d), "R4 lead width", gotDn, leadRef ? 0 : d);
    if (m > 0) modelRun = 0;
    good = (d <= 1);
    modelRun = good ? modelRun + 1 : 0;
    chk(lockedOut == (modelRun >= LCK), "R7 lock flag", int'(lockedOut),
        int'(modelRun >= LCK));
  endtask

  initial begin
    int nSel [4] = '{4, 5, 8, 10};
    void'($urandom(32'h5eed1234));
    repeat (4) tick(0, 0, 0);
    chk(selOut == 0 && upOut == 0 && dnOut == 0 && lockedOut == 0 && widthValid == 0 &&
        missOut == 0 && resetReqOut == 0 && upWidth == 0 && dnWidth == 0,
        "R8 outputs in reset", int'(selOut | upOut | dnOut | lockedOut), 0);
    rstN = 1'b1;
    tick(0, 0, 0);
    chk(selOut == 0 && lockedOut == 0, "R8 after release", int'(selOut), 0);

    // lock build-up then loss (R7)
    window(4, 1, 1, 0);
    window(8, 0, 1, 0);
    window(5, 1, 0, 0);
    window(10, 1, 1, 0);
    window(4, 0, 0, 0);
    window(8, 3, 1, 0);
    // miss boundaries and consecutive run (R5, R6)
    window(4, 0, 1, TMO - 2);
    window(4, 0, 1, TMO - 1);
    window(4, 0, 1, 3 * TMO + 4);
    window(5, 1, 1, 2 * TMO + 4);
    window(5, 1, 1, 2 * TMO + 4);
    // random windows
    for (int i = 0; i < 30; i++)
      window(nSel[$urandom % 4], int'($urandom % 6), 1'($urandom % 2), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule